// File: doc/BRIEF.md
# Multi-format stereo audio serial receiver

The receiver takes a stereo PCM stream carried on three wires: a bit clock, which also clocks the whole block, a word clock that separates the two channels, and one serial data line. Data and word clock are sampled on each rising bit-clock edge. A 3-bit format code picks the word length (16, 20 or 24 bits) and how the word sits in its half-frame. The choices are right-justified, left-justified MSB-first, or I2S with a one-bit delay. Each completed stereo frame gives one left/right pair. Both words are sign-extended to 24 bits. The pair is offered on a valid/ready output.

The serial source cannot be paused, so back-pressure is lossy by design. A pair stays on the output, unchanged, until the sink takes it with `out_ready`. If the next pair completes before the held one is taken, the newer pair replaces it and `overrun` pulses for one cycle. If the sink takes the held pair on the same edge that the next pair loads, nothing is lost. The format code is expected to be static. It is applied whenever reset is released.

Top module: `aud_serial_rx`

## Requirements
- R1: Format codes 000, 010 and 100 select right-justified words of 16, 20 and 24 bits. A word is the last N bits sampled before the word-clock transition that ends its half-frame. Word clock high marks left. The pair loads on the edge after that transition.
- R2: Code 110 selects 24-bit left-justified words. The MSB is sampled on the first rising edge that sees the new word-clock level, and word clock high marks left.
- R3: Codes 001 and 011 select 16-bit and 24-bit I2S. The MSB is sampled on the second rising edge after the transition, and word clock low marks left.
- R4: A half-frame may be longer than the word: at least N bit clocks for right- and left-justified framing, and at least N+1 for I2S. The bits outside the word have no effect on the output.
- R5: 16-bit and 20-bit words appear on `out_left`/`out_right` sign-extended to 24 bits.
- R6: Codes 101 and 111 are reserved. `fmt_err` is high from the first edge after reset release. Framing is treated as 24-bit left-justified, so one pair per frame is still produced, but both samples are zero.
- R7: Exactly one pair is produced per stereo frame: a left word, then the following right word. The half-frame in progress at reset release is discarded. For left-justified and I2S framing, the pair loads on the edge after the one that samples the right word's last bit.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_left` and `out_right` hold, unless a newer pair loads. A pair is taken on a rising edge with both signals high.
- R9: A pair that completes while the held pair is not taken replaces it, and `overrun` pulses for one cycle. A pair that loads on the edge where the held pair is taken raises no overrun, and `out_valid` stays high.
- R10: While reset is low, `out_valid`, `overrun` and `fmt_err` are low and both sample outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| word_clk | input | 1 | Channel select / frame clock |
| sdata | input | 1 | Serial audio data |
| fmt_code | input | 3 | Word length and alignment code |
| out_ready | input | 1 | Sink accepts the offered pair |
| out_valid | output | 1 | A stereo pair is offered |
| out_left | output | 24 | Left sample, sign-extended |
| out_right | output | 24 | Right sample, sign-extended |
| overrun | output | 1 | One-cycle pulse: an unaccepted pair was replaced |
| fmt_err | output | 1 | Reserved format code selected |

## Verification
Two output-stage functions can fall on the same rising edge: the sink taking the held pair, and the next pair loading from the framer. The bench holds `out_ready` low so a pair waits. It then raises `out_ready` for exactly the one edge on which the next left-justified pair loads. That edge is computed from the bit slot of the right word's last bit. The result is judged by the taken pair matching the first frame, the output staying valid with the second frame, and no overrun being counted. A later frame is then sent with the sink stalled, which must produce exactly one overrun and leave the newest pair on the output.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;

  localparam int unsigned LEN_W = 6;

  typedef enum logic [1:0] {
    ALN_RIGHT = 2'd0,
    ALN_LEFT  = 2'd1,
    ALN_I2S   = 2'd2
  } align_e;

  typedef struct packed {
    align_e           align;
    logic [LEN_W-1:0] len;
    logic             bad;
  } rx_cfg_t;

  // Code bit order {length-hi, length-lo, i2s}
  function automatic rx_cfg_t decode_fmt(input logic [2:0] code);
    rx_cfg_t c;
    c.bad   = 1'b0;
    c.align = ALN_LEFT;
    c.len   = LEN_W'(24);
    unique case (code)
      3'b000: begin c.align = ALN_RIGHT; c.len = LEN_W'(16); end
      3'b010: begin c.align = ALN_RIGHT; c.len = LEN_W'(20); end
      3'b100: begin c.align = ALN_RIGHT; c.len = LEN_W'(24); end
      3'b110: begin c.align = ALN_LEFT;  c.len = LEN_W'(24); end
      3'b001: begin c.align = ALN_I2S;   c.len = LEN_W'(16); end
      3'b011: begin c.align = ALN_I2S;   c.len = LEN_W'(24); end
      default: begin c.align = ALN_LEFT; c.len = LEN_W'(24); c.bad = 1'b1; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/aud_fmt_decode.sv
module aud_fmt_decode
  import aud_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] fmt_code,
  output rx_cfg_t    cfg_q,
  output logic       fmt_err
);

  rx_cfg_t cfg_d;

  always_comb cfg_d = decode_fmt(fmt_code);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '{align: ALN_RIGHT, len: LEN_W'(16), bad: 1'b0};
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign fmt_err = cfg_q.bad;

endmodule

// File: rtl/aud_bit_framer.sv
module aud_bit_framer
  import aud_rx_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_clk,
  input  logic         sdata,
  input  rx_cfg_t      cfg,
  output logic         cap_valid,
  output logic         cap_right,
  output logic [W-1:0] cap_word
);

  localparam int unsigned CW = $clog2(W + 2);
  localparam int unsigned IW = $clog2(W);
  localparam logic [CW-1:0] POS_MAX = '1;

  logic [W-1:0]  sr, sr_next;
  logic [CW-1:0] idx, pos;
  logic          wc_q, primed, synced, wc_edge;
  logic          take, take_right;
  logic [W-1:0]  take_src, word_d;

  function automatic logic [W-1:0] sext(input logic [W-1:0] src, input logic [LEN_W-1:0] len);
    logic [W-1:0] r;
    int           top;
    logic [IW-1:0] topi;
    top = (int'(len) > 0) ? int'(len) - 1 : 0;
    if (top > int'(W) - 1) top = int'(W) - 1;
    topi = IW'(top);
    for (int i = 0; i < int'(W); i++) begin
      r[i] = (i <= top) ? src[i] : src[topi];
    end
    return r;
  endfunction

  // Bit position inside the current half-frame; saturates until a transition
  always_comb begin
    wc_edge = primed && (word_clk != wc_q);
    if (wc_edge)           pos = '0;
    else if (idx == POS_MAX) pos = idx;
    else                   pos = idx + 1'b1;
    sr_next = {sr[W-2:0], sdata};
  end

  always_comb begin
    take       = 1'b0;
    take_right = 1'b0;
    take_src   = sr_next;
    unique case (cfg.align)
      ALN_RIGHT: begin
        // word ends just before the transition: register holds it untouched
        take       = wc_edge && synced;
        take_right = !wc_q;
        take_src   = sr;
      end
      ALN_LEFT: begin
        take       = (pos == CW'(int'(cfg.len) - 1));
        take_right = !word_clk;
      end
      ALN_I2S: begin
        take       = (pos == CW'(cfg.len));
        take_right = word_clk;
      end
      default: take = 1'b0;
    endcase
    word_d = cfg.bad ? '0 : sext(take_src, cfg.len);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr        <= '0;
      idx       <= POS_MAX;
      wc_q      <= 1'b0;
      primed    <= 1'b0;
      synced    <= 1'b0;
      cap_valid <= 1'b0;
      cap_right <= 1'b0;
      cap_word  <= '0;
    end else begin
      primed    <= 1'b1;
      wc_q      <= word_clk;
      sr        <= sr_next;
      idx       <= pos;
      if (wc_edge) synced <= 1'b1;
      cap_valid <= take;
      if (take) begin
        cap_right <= take_right;
        cap_word  <= word_d;
      end
    end
  end

  a_r5_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && $past(cfg.len) == LEN_W'(16))
      |-> (cap_word[W-1:15] == '0 || cap_word[W-1:15] == '1));

  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && $past(cfg.bad)) |-> (cap_word == '0));

endmodule

// File: rtl/aud_pair_out.sv
module aud_pair_out #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_valid,
  input  logic         cap_right,
  input  logic [W-1:0] cap_word,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_right,
  output logic         overrun
);

  logic [W-1:0] left_hold;
  logic         left_ok;
  logic         pair_done;

  assign pair_done = cap_valid && cap_right && left_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_hold <= '0;
      left_ok   <= 1'b0;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
      overrun   <= 1'b0;
    end else begin
      if (cap_valid && !cap_right) begin
        left_hold <= cap_word;
        left_ok   <= 1'b1;
      end else if (pair_done) begin
        left_ok   <= 1'b0;
      end
      if (pair_done) begin
        out_left  <= left_hold;
        out_right <= cap_word;
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      overrun <= pair_done && out_valid && !out_ready;
    end
  end

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !pair_done)
      |=> (out_valid && $stable(out_left) && $stable(out_right)));

  a_r9_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(out_valid && !out_ready));

  a_r9_handover: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && pair_done) |=> (out_valid && !overrun));

  a_r7_pair_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(cap_valid && cap_right));

endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                bclk,
  input  logic                rst_n,
  input  logic                word_clk,
  input  logic                sdata,
  input  logic [2:0]          fmt_code,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_left,
  output logic [SAMPLE_W-1:0] out_right,
  output logic                overrun,
  output logic                fmt_err
);

  rx_cfg_t             cfg_q;
  logic                cap_valid, cap_right;
  logic [SAMPLE_W-1:0] cap_word;

  aud_fmt_decode u_dec (
    .clk      (bclk),
    .rst_n    (rst_n),
    .fmt_code (fmt_code),
    .cfg_q    (cfg_q),
    .fmt_err  (fmt_err)
  );

  aud_bit_framer #(.W(SAMPLE_W)) u_framer (
    .clk       (bclk),
    .rst_n     (rst_n),
    .word_clk  (word_clk),
    .sdata     (sdata),
    .cfg       (cfg_q),
    .cap_valid (cap_valid),
    .cap_right (cap_right),
    .cap_word  (cap_word)
  );

  aud_pair_out #(.W(SAMPLE_W)) u_pair (
    .clk       (bclk),
    .rst_n     (rst_n),
    .cap_valid (cap_valid),
    .cap_right (cap_right),
    .cap_word  (cap_word),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_left  (out_left),
    .out_right (out_right),
    .overrun   (overrun)
  );

endmodule

// File: tb/aud_serial_rx_bench.sv
module aud_serial_rx_bench;

  localparam int CLK_P = 10;
  localparam int NP    = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_clk = 1'b0;
  logic        sdata = 1'b0;
  logic [2:0]  fmt_code = 3'b000;
  logic        out_ready = 1'b1;
  logic        out_valid, overrun, fmt_err;
  logic [23:0] out_left, out_right;

  int    total = 0, bad = 0, ovr_cnt = 0, got_cnt = 0;
  logic  rdy_def = 1'b1;
  string cur_tag = "R1";
  logic [23:0] q_l[$];
  logic [23:0] q_r[$];

  always #(CLK_P/2) clk = ~clk;

  aud_serial_rx u_aud_serial_rx (
    .bclk(clk), .rst_n(rst_n), .word_clk(word_clk), .sdata(sdata),
    .fmt_code(fmt_code), .out_ready(out_ready), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right), .overrun(overrun), .fmt_err(fmt_err)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] ext_b(input int w, input int n);
    int m = (1 << n) - 1;
    int v = w & m;
    if (((v >> (n - 1)) & 1) != 0) v = v | ~m;
    return 24'(v);
  endfunction

  function automatic int samp(input int p, input int n, input int side);
    int m = (1 << n) - 1;
    int q;
    int v;
    if (p < 4) begin
      q = (p + side * 2) % 4;
      case (q)
        0: v = 1 << (n - 1);
        1: v = (1 << (n - 1)) - 1;
        2: v = 0;
        default: v = m;
      endcase
    end else begin
      v = p * 40503 + side * 9973 + 12345;
    end
    return v & m;
  endfunction

  // Monitor: looks just after the falling edge, when inputs for the next rising edge are settled
  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid && out_ready) begin
      got_cnt++;
      if (q_l.size() == 0) begin
        chk(1'b0, cur_tag, "unexpected pair", out_left, 24'h0);
      end else begin
        logic [23:0] el, er;
        el = q_l.pop_front();
        er = q_r.pop_front();
        chk(out_left == el, cur_tag, "left sample", out_left, el);
        chk(out_right == er, cur_tag, "right sample", out_right, er);
      end
    end
    if (rst_n && overrun) ovr_cnt++;
  end

  task automatic drive(input logic b, input logic lvl, input int s, input int hand);
    @(negedge clk);
    word_clk  = lvl;
    sdata     = b;
    out_ready = (s == hand) ? 1'b1 : rdy_def;
  endtask

  // aln: 0 right-justified, 1 left-justified, 2 one-bit-delayed
  task automatic send_half(input logic lvl, input int w, input int n, input int aln,
                           input int h, input int hand, input int jseed);
    for (int s = 0; s < h; s++) begin
      logic b;
      b = (((s * 5 + jseed) % 3) == 0);   // filler outside the word (R4)
      case (aln)
        0: if (s >= h - n) b = ((w >> (h - 1 - s)) & 1) != 0;
        1: if (s < n) b = ((w >> (n - 1 - s)) & 1) != 0;
        default: if (s >= 1 && s <= n) b = ((w >> (n - s)) & 1) != 0;
      endcase
      drive(b, lvl, s, hand);
    end
  endtask

  task automatic do_reset(input logic [2:0] code, input logic idle_lvl);
    rst_n = 1'b0;
    fmt_code = code;
    word_clk = idle_lvl;
    sdata = 1'b0;
    out_ready = rdy_def;
    repeat (3) @(negedge clk);
    #2;
    chk(out_valid == 1'b0, "R10", "out_valid in reset", 24'(out_valid), 24'h0);
    chk(out_left == 24'h0 && out_right == 24'h0, "R10", "samples in reset", out_left | out_right, 24'h0);
    chk(overrun == 1'b0 && fmt_err == 1'b0, "R10", "flags in reset", 24'({overrun, fmt_err}), 24'h0);
    @(negedge clk);
    rst_n = 1'b1;
    ovr_cnt = 0;
    got_cnt = 0;
    q_l.delete();
    q_r.delete();
    repeat (3) @(negedge clk);
  endtask

  task automatic run_fmt(input logic [2:0] code, input int h);
    int n, aln, exp_pairs;
    logic lvl_l, badf;
    badf = 1'b0; n = 24; aln = 1; lvl_l = 1'b1;
    case (code)
      3'b000: begin n = 16; aln = 0; cur_tag = "R1/R4/R5"; end
      3'b010: begin n = 20; aln = 0; cur_tag = "R1/R4/R5"; end
      3'b100: begin n = 24; aln = 0; cur_tag = "R1/R4"; end
      3'b110: begin n = 24; aln = 1; cur_tag = "R2/R4"; end
      3'b001: begin n = 16; aln = 2; lvl_l = 1'b0; cur_tag = "R3/R4/R5"; end
      3'b011: begin n = 24; aln = 2; lvl_l = 1'b0; cur_tag = "R3/R4"; end
      default: begin badf = 1'b1; cur_tag = "R6"; end
    endcase
    rdy_def = 1'b1;
    do_reset(code, ~lvl_l);
    #2;
    chk(fmt_err == badf, "R6", "fmt_err level", 24'(fmt_err), 24'(badf));
    send_half(~lvl_l, 24'hA5C3E1, n, aln, h, -1, 7);   // discarded partial half (R7)
    exp_pairs = 0;
    for (int p = 0; p < NP; p++) begin
      int lw, rw;
      lw = samp(p, n, 0);
      rw = samp(p, n, 1);
      q_l.push_back(badf ? 24'h0 : ext_b(lw, n));
      q_r.push_back(badf ? 24'h0 : ext_b(rw, n));
      exp_pairs++;
      send_half(lvl_l, lw, n, aln, h, -1, p);
      send_half(~lvl_l, rw, n, aln, h, -1, p + 1);
    end
    send_half(lvl_l, 0, n, aln, h, -1, 2);
    repeat (4) drive(1'b0, lvl_l, -1, -1);
    #2;
    chk(got_cnt == exp_pairs, "R7", "pairs per run", 24'(got_cnt), 24'(exp_pairs));
    chk(q_l.size() == 0, "R7", "pairs left over", 24'(q_l.size()), 24'h0);
    chk(ovr_cnt == 0, "R9", "overrun with sink ready", 24'(ovr_cnt), 24'h0);
  endtask

  // Stalled sink, same-edge handover, then overrun (R8, R9)
  task automatic bp_test();
    int l0, r0, l1, r1, l2, r2;
    cur_tag = "R8/R9";
    rdy_def = 1'b0;
    do_reset(3'b110, 1'b0);
    l0 = samp(4, 24, 0); r0 = samp(4, 24, 1);
    l1 = samp(5, 24, 0); r1 = samp(5, 24, 1);
    l2 = samp(0, 24, 0); r2 = samp(0, 24, 1);
    send_half(1'b0, 0, 24, 1, 32, -1, 3);
    q_l.push_back(ext_b(l0, 24)); q_r.push_back(ext_b(r0, 24));
    send_half(1'b1, l0, 24, 1, 32, -1, 0);
    send_half(1'b0, r0, 24, 1, 32, -1, 1);
    send_half(1'b1, l1, 24, 1, 32, -1, 2);
    // right word's last bit sits in slot 23; the pair loads on slot 24's edge
    send_half(1'b0, r1, 24, 1, 32, 24, 0);
    #2;
    chk(got_cnt == 1, "R9", "handover took first pair", 24'(got_cnt), 24'h1);
    chk(out_valid == 1'b1, "R9", "valid kept across handover", 24'(out_valid), 24'h1);
    chk(out_left == ext_b(l1, 24), "R9", "second pair offered", out_left, ext_b(l1, 24));
    chk(ovr_cnt == 0, "R9", "no overrun on handover", 24'(ovr_cnt), 24'h0);
    q_l.push_back(ext_b(l2, 24)); q_r.push_back(ext_b(r2, 24));
    send_half(1'b1, l2, 24, 1, 32, -1, 1);
    send_half(1'b0, r2, 24, 1, 32, -1, 2);
    send_half(1'b1, 0, 24, 1, 32, -1, 0);
    #2;
    chk(ovr_cnt == 1, "R9", "overrun pulses", 24'(ovr_cnt), 24'h1);
    chk(out_valid == 1'b1, "R8", "valid held while stalled", 24'(out_valid), 24'h1);
    chk(out_left == ext_b(l2, 24), "R8", "newest left held", out_left, ext_b(l2, 24));
    chk(out_right == ext_b(r2, 24), "R8", "newest right held", out_right, ext_b(r2, 24));
    rdy_def = 1'b1;
    repeat (3) drive(1'b0, 1'b1, -1, -1);
    #2;
    chk(got_cnt == 2, "R8", "pairs taken", 24'(got_cnt), 24'h2);
    chk(out_valid == 1'b0, "R8", "valid drops after take", 24'(out_valid), 24'h0);
  endtask

  initial begin
    #(CLK_P * 100000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 8; c++) begin
      run_fmt(3'(c), 25);
      run_fmt(3'(c), 32);
      run_fmt(3'(c), 40);
    end
    bp_test();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule